// File: doc/BRIEF.md
# Bus-Attached Eight-Pin Bidirectional Port

This block connects eight general-purpose pins to a simple processor memory bus. The bus presents a word address (bits 31 down to 2), a read/not-write flag, a master enable, four byte enables and 32-bit write and read data. Two word addresses are decoded. The first holds the port data and the second holds the direction settings. A write to the data word loads an output latch. A read of the data word returns the levels currently present on the pins, not the latch. A write to the direction word sets, bit by bit, which pins the port drives. The direction word cannot be read.

The pads, the tri-state cells and the pull-up resistors are outside the block. The port hands them a drive value and an output enable for each pin, and it receives the resolved pin level back. Before a read uses that level, it passes through a synchronizer. On the shared bus, read data and the acknowledge each come out as a value plus an enable. The enable is high only in a cycle that the port claims, so other devices are free to use the bus in every other cycle.

Each bus cycle is classified combinationally into one of four access states: `ACC_IDLE` (no claim), `ACC_DATA_RD`, `ACC_DATA_WR` and `ACC_DIR_WR`. The register stage holds the direction and latch state. It takes a `ACC_DIR_WR` transition to load the direction, takes a `ACC_DATA_WR` transition to load the latch, and holds both under `ACC_IDLE` and `ACC_DATA_RD`.

Top module: `pport_top`

## Requirements
- R1: Reset clears the direction register and the output latch to 0, so every `pin_oe` bit is 0 and `pin_out` is 0.
- R2: A write (`bus_rnw`=0) to word address 0x3FC445 (byte address 0x00FF1114) with `bus_me`=1 and `bus_be[0]`=1 loads `bus_wdata[7:0]` into the direction register. `pin_oe` shows the new value after that clock edge. A 1 bit makes the pin an output.
- R3: A qualified write to word address 0x3FC444 (byte address 0x00FF1110) loads `bus_wdata[7:0]` into the output latch. The value appears on a pin only where that pin's direction bit is 1.
- R4: A qualified read (`bus_rnw`=1) of word 0x3FC444 raises `bus_rdata_oe` in the same cycle. `bus_rdata[7:0]` then carries the pin levels as sampled two clock edges earlier, and `bus_rdata[31:8]` is 0. When `bus_rdata_oe` is 0, `bus_rdata` is 0.
- R5: A pin that is released and not driven externally reads back as 1, because of the external weak pull-up.
- R6: A data read returns the pin level, not the latch. An input pin that is driven externally reads as the external value, whatever the latch holds.
- R7: An access with `bus_me`=0, with `bus_be[0]`=0, or to any other word address is not claimed. `bus_ack_oe` and `bus_rdata_oe` stay 0, and the direction and latch state do not change.
- R8: A read of the direction word address is not claimed. `bus_ack_oe` and `bus_rdata_oe` stay 0.
- R9: `bus_ack_oe` is 1 exactly in the cycle of a claimed access. In that cycle `bus_ack` is 1.
- R10: Only byte lane 0 carries port data. `bus_wdata[31:8]` has no effect on the direction register or the latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 30 | Word address, byte address bits 31:2 |
| bus_rnw | input | 1 | 1 = read, 0 = write |
| bus_me | input | 1 | Master enable, the access is valid |
| bus_be | input | 4 | Byte enables, lane 0 carries port data |
| bus_wdata | input | 32 | Write data from the processor |
| bus_rdata | output | 32 | Read data drive value |
| bus_rdata_oe | output | 1 | Read data drive enable |
| bus_ack | output | 1 | Acknowledge drive value |
| bus_ack_oe | output | 1 | Acknowledge drive enable, low = released |
| pin_in | input | 8 | Resolved pin levels from the pads |
| pin_out | output | 8 | Output latch value to the pads |
| pin_oe | output | 8 | Per-pin output enable, the direction register |

## Verification
The acknowledge and the read data are combinational. They are due within the access cycle, so the bench drives the bus on a falling edge, samples the acknowledge 1 ns later, and has the scoreboard monitor compare the read data 3 ns after the falling edge, both before the rising edge that ends the cycle. The direction and latch writes take effect at that rising edge, so `pin_oe`, `pin_out` and the resolved pin levels are checked 1 ns after it. A pin change reaches read data only after two further rising edges. One sequence reads three times in a row after an external pin change and expects old, old, then new. Every other read waits two edges after the last pin change.

// File: rtl/pport_pkg.sv
package pport_pkg;

    // Access states for one bus cycle
    typedef enum logic [1:0] {
        ACC_IDLE    = 2'd0,
        ACC_DATA_RD = 2'd1,
        ACC_DATA_WR = 2'd2,
        ACC_DIR_WR  = 2'd3
    } acc_kind_t;

    localparam int unsigned ADDR_W_DEF = 30;
    localparam int unsigned BUS_W_DEF  = 32;
    localparam int unsigned BE_W_DEF   = 4;

endpackage

// File: rtl/pport_decode.sv
module pport_decode
    import pport_pkg::*;
#(
    parameter int unsigned    ADDR_W    = 30,
    parameter int unsigned    BE_W      = 4,
    parameter logic [ADDR_W-1:0] DATA_WADDR = 30'h03FC444,
    parameter logic [ADDR_W-1:0] DIR_WADDR  = 30'h03FC445
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              rnw,
    input  logic              me,
    input  logic [BE_W-1:0]   be,
    output acc_kind_t         kind
);

    logic hit_data;
    logic hit_dir;
    logic qual;

    always_comb begin
        hit_data = (addr == DATA_WADDR);
        hit_dir  = (addr == DIR_WADDR);
        qual     = me & be[0];
    end

    always_comb begin
        kind = ACC_IDLE;
        if (qual) begin
            unique case ({hit_data, hit_dir, rnw})
                3'b101:  kind = ACC_DATA_RD;
                3'b100:  kind = ACC_DATA_WR;
                3'b010:  kind = ACC_DIR_WR;
                default: kind = ACC_IDLE;
            endcase
        end
    end

    // R7: a claimed access always carries the master enable and byte lane 0
    a_r7_claim_qualified: assert property (@(posedge clk) disable iff (!rst_n)
        (kind != ACC_IDLE) |-> (me && be[0]));

    // R8: reads at the direction address are never claimed
    a_r8_dir_read_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (rnw && addr == DIR_WADDR) |-> (kind == ACC_IDLE));

endmodule

// File: rtl/pport_sync.sv
module pport_sync #(
    parameter int unsigned WIDTH  = 8,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    localparam int unsigned LAST = STAGES - 1;

    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        logic [STAGES-1:0] chain;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                chain <= '1;
            end else if (STAGES == 1) begin
                chain[0] <= d[b];
            end else begin
                chain <= {chain[STAGES-2:0], d[b]};
            end
        end

        assign q[b] = chain[LAST];
    end

endmodule

// File: rtl/pport_regs.sv
module pport_regs
    import pport_pkg::*;
#(
    parameter int unsigned WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  acc_kind_t        kind,
    input  logic [WIDTH-1:0] wbyte,
    output logic [WIDTH-1:0] dir_q,
    output logic [WIDTH-1:0] latch_q
);

    logic [WIDTH-1:0] dir_d;
    logic [WIDTH-1:0] latch_d;

    // Next-state selection by access state
    always_comb begin
        dir_d   = dir_q;
        latch_d = latch_q;
        unique case (kind)
            ACC_DIR_WR:  dir_d   = wbyte;
            ACC_DATA_WR: latch_d = wbyte;
            ACC_DATA_RD,
            ACC_IDLE:    ;
            default:     ;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir_q   <= '0;
            latch_q <= '0;
        end else begin
            dir_q   <= dir_d;
            latch_q <= latch_d;
        end
    end

    // R2: a direction write lands after the edge
    a_r2_dir_load: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == ACC_DIR_WR) |=> (dir_q == $past(wbyte)));

    // R3: a data write lands in the latch after the edge
    a_r3_latch_load: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == ACC_DATA_WR) |=> (latch_q == $past(wbyte)));

    // R7: without a matching write the state holds
    a_r7_latch_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (kind != ACC_DATA_WR) |=> $stable(latch_q));

    a_r7_dir_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (kind != ACC_DIR_WR) |=> $stable(dir_q));

endmodule

// File: rtl/pport_top.sv
module pport_top
    import pport_pkg::*;
#(
    parameter int unsigned ADDR_W      = 30,
    parameter int unsigned BUS_W       = 32,
    parameter int unsigned BE_W        = 4,
    parameter int unsigned PINS        = 8,
    parameter int unsigned SYNC_STAGES = 2,
    parameter logic [ADDR_W-1:0] DATA_WADDR = 30'h03FC444,
    parameter logic [ADDR_W-1:0] DIR_WADDR  = 30'h03FC445
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rnw,
    input  logic              bus_me,
    input  logic [BE_W-1:0]   bus_be,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    output logic              bus_rdata_oe,
    output logic              bus_ack,
    output logic              bus_ack_oe,
    input  logic [PINS-1:0]   pin_in,
    output logic [PINS-1:0]   pin_out,
    output logic [PINS-1:0]   pin_oe
);

    localparam int unsigned PAD_W = BUS_W - PINS;

    acc_kind_t       kind;
    logic [PINS-1:0] pin_sync;
    logic [PINS-1:0] dir_q;
    logic [PINS-1:0] latch_q;

    pport_decode #(
        .ADDR_W     (ADDR_W),
        .BE_W       (BE_W),
        .DATA_WADDR (DATA_WADDR),
        .DIR_WADDR  (DIR_WADDR)
    ) u_decode (
        .clk   (clk),
        .rst_n (rst_n),
        .addr  (bus_addr),
        .rnw   (bus_rnw),
        .me    (bus_me),
        .be    (bus_be),
        .kind  (kind)
    );

    pport_sync #(
        .WIDTH  (PINS),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pin_in),
        .q     (pin_sync)
    );

    pport_regs #(
        .WIDTH (PINS)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .kind    (kind),
        .wbyte   (bus_wdata[PINS-1:0]),
        .dir_q   (dir_q),
        .latch_q (latch_q)
    );

    // Bus response outputs
    always_comb begin
        bus_ack_oe   = 1'b0;
        bus_rdata_oe = 1'b0;
        bus_rdata    = '0;
        unique case (kind)
            ACC_DATA_RD: begin
                bus_ack_oe   = 1'b1;
                bus_rdata_oe = 1'b1;
                bus_rdata    = {{PAD_W{1'b0}}, pin_sync};
            end
            ACC_DATA_WR,
            ACC_DIR_WR: bus_ack_oe = 1'b1;
            ACC_IDLE:   ;
            default:    ;
        endcase
        bus_ack = bus_ack_oe;
    end

    assign pin_out = latch_q;
    assign pin_oe  = dir_q;

    // R4: read data upper bits stay zero
    a_r4_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rdata[BUS_W-1:PINS] == '0);

    // R4: read data is enabled only inside a claimed read
    a_r4_rdata_in_read: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rdata_oe |-> (bus_rnw && bus_ack_oe));

    // R9: an enabled acknowledge is always a high level
    a_r9_ack_high: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ack_oe |-> bus_ack);

    // R7: no claim without the master enable
    a_r7_no_me_no_ack: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_me |-> !bus_ack_oe);

endmodule

// File: tb/sim_pport_top.sv
module sim_pport_top;

    localparam time CLK_PERIOD = 10ns;
    localparam logic [29:0] A_DATA = 30'h03FC444;
    localparam logic [29:0] A_DIR  = 30'h03FC445;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [29:0] bus_addr = '0;
    logic        bus_rnw = 1'b0;
    logic        bus_me = 1'b0;
    logic [3:0]  bus_be = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_rdata_oe;
    logic        bus_ack;
    logic        bus_ack_oe;
    logic [7:0]  pin_in;
    logic [7:0]  pin_out;
    logic [7:0]  pin_oe;

    // External pad model: weak pull-up, optional external driver
    logic [7:0] ext_drv = '0;
    logic [7:0] ext_val = '0;
    logic [7:0] pin_lvl;

    for (genvar i = 0; i < 8; i++) begin : g_pad
        assign pin_lvl[i] = pin_oe[i] ? pin_out[i] : (ext_drv[i] ? ext_val[i] : 1'b1);
    end
    assign pin_in = pin_lvl;

    int n_checks = 0;
    int n_fail   = 0;

    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    pport_top u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .bus_addr     (bus_addr),
        .bus_rnw      (bus_rnw),
        .bus_me       (bus_me),
        .bus_be       (bus_be),
        .bus_wdata    (bus_wdata),
        .bus_rdata    (bus_rdata),
        .bus_rdata_oe (bus_rdata_oe),
        .bus_ack      (bus_ack),
        .bus_ack_oe   (bus_ack_oe),
        .pin_in       (pin_in),
        .pin_out      (pin_out),
        .pin_oe       (pin_oe)
    );

    task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Driver: one bus cycle; pushes expected read bytes to the scoreboard
    task automatic bus_op(input logic [29:0] a, input logic rnw, input logic [3:0] be,
                          input logic me, input logic [31:0] wd, input logic claim,
                          input logic [7:0] exp, input string tag);
        @(negedge clk);
        bus_addr  = a;
        bus_rnw   = rnw;
        bus_be    = be;
        bus_me    = me;
        bus_wdata = wd;
        if (claim && rnw) begin
            exp_q.push_back(exp);
            tag_q.push_back(tag);
        end
        #1;
        chk(bus_ack_oe == claim, {tag, " R9 ack_oe"}, 32'(bus_ack_oe), 32'(claim));
        if (claim)
            chk(bus_ack == 1'b1, {tag, " R9 ack level"}, 32'(bus_ack), 32'd1);
        chk(bus_rdata_oe == (claim && rnw), {tag, " R4 rdata_oe"}, 32'(bus_rdata_oe), 32'(claim && rnw));
        @(posedge clk);
        #1;
        bus_me    = 1'b0;
        bus_be    = '0;
        bus_rnw   = 1'b0;
        bus_wdata = '0;
    endtask

    // Monitor: compares read data against the scoreboard
    initial begin
        forever begin
            @(negedge clk);
            #3;
            if (bus_rdata_oe) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R4 unexpected read data", bus_rdata, 32'd0);
                end else begin
                    logic [7:0] e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    chk(bus_rdata == {24'd0, e}, t, bus_rdata, {24'd0, e});
                end
            end else begin
                chk(bus_rdata == 32'd0, "R4 idle rdata zero", bus_rdata, 32'd0);
            end
        end
    end

    task automatic settle();
        repeat (2) @(posedge clk);
        #1;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        chk(1'b0, "watchdog expired", 32'd0, 32'd1);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R1: reset state
        chk(pin_oe == 8'h00, "R1 pin_oe reset", 32'(pin_oe), 32'h0);
        chk(pin_out == 8'h00, "R1 pin_out reset", 32'(pin_out), 32'h0);
        chk(bus_ack_oe == 1'b0, "R1 ack released", 32'(bus_ack_oe), 32'h0);
        rst_n = 1'b1;
        settle();

        // R5: all released and undriven read 1
        bus_op(A_DATA, 1'b1, 4'b0001, 1'b1, 32'h0, 1'b1, 8'hFF, "R5 undriven read");

        // R2 and R10: direction write with junk in upper lanes
        bus_op(A_DIR, 1'b0, 4'b1111, 1'b1, 32'hABCDEFF0, 1'b1, 8'h00, "R2 dir write");
        chk(pin_oe == 8'hF0, "R2 R10 pin_oe", 32'(pin_oe), 32'hF0);

        // R3: latch write, only outputs show it
        bus_op(A_DATA, 1'b0, 4'b0001, 1'b1, 32'h7766555A, 1'b1, 8'h00, "R3 data write");
        chk(pin_out == 8'h5A, "R3 R10 latch", 32'(pin_out), 32'h5A);
        chk(pin_lvl == 8'h5F, "R3 pin levels", 32'(pin_lvl), 32'h5F);
        settle();
        bus_op(A_DATA, 1'b1, 4'b0001, 1'b1, 32'h0, 1'b1, 8'h5F, "R4 read mixed pins");

        // R6: external drive on inputs wins over latch
        ext_drv = 8'h0F;
        ext_val = 8'h03;
        settle();
        bus_op(A_DATA, 1'b1, 4'b0001, 1'b1, 32'h0, 1'b1, 8'h53, "R6 read pin not latch");

        // R4: two-edge sync latency: old, old, new
        ext_val = 8'h0C;
        bus_op(A_DATA, 1'b1, 4'b0001, 1'b1, 32'h0, 1'b1, 8'h53, "R4 latency read 0");
        bus_op(A_DATA, 1'b1, 4'b0001, 1'b1, 32'h0, 1'b1, 8'h53, "R4 latency read 1");
        bus_op(A_DATA, 1'b1, 4'b0001, 1'b1, 32'h0, 1'b1, 8'h5C, "R4 latency read 2");

        // R7: unqualified accesses
        bus_op(A_DATA, 1'b0, 4'b0001, 1'b0, 32'h000000A5, 1'b0, 8'h00, "R7 no me write");
        chk(pin_out == 8'h5A, "R7 latch after no-me write", 32'(pin_out), 32'h5A);
        bus_op(A_DIR, 1'b0, 4'b1110, 1'b1, 32'h000000FF, 1'b0, 8'h00, "R7 be0 low write");
        chk(pin_oe == 8'hF0, "R7 dir after be0-low write", 32'(pin_oe), 32'hF0);
        bus_op(A_DATA + 30'd2, 1'b0, 4'b0001, 1'b1, 32'h00000000, 1'b0, 8'h00, "R7 wrong address");
        chk(pin_out == 8'h5A, "R7 latch after wrong address", 32'(pin_out), 32'h5A);
        bus_op(A_DATA, 1'b1, 4'b0001, 1'b0, 32'h0, 1'b0, 8'h00, "R7 no me read");

        // R8: direction address read not claimed
        bus_op(A_DIR, 1'b1, 4'b0001, 1'b1, 32'h0, 1'b0, 8'h00, "R8 dir read");

        // R2: all inputs again
        bus_op(A_DIR, 1'b0, 4'b0001, 1'b1, 32'h00000000, 1'b1, 8'h00, "R2 dir clear");
        chk(pin_oe == 8'h00, "R2 pin_oe cleared", 32'(pin_oe), 32'h0);
        settle();
        bus_op(A_DATA, 1'b1, 4'b0001, 1'b1, 32'h0, 1'b1, 8'hFC, "R5 R6 all inputs read");

        // R1: reset mid-run
        bus_op(A_DIR, 1'b0, 4'b0001, 1'b1, 32'h000000FF, 1'b1, 8'h00, "R2 dir all out");
        chk(pin_oe == 8'hFF, "R2 pin_oe all", 32'(pin_oe), 32'hFF);
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        chk(pin_oe == 8'h00, "R1 pin_oe after reset", 32'(pin_oe), 32'h0);
        chk(pin_out == 8'h00, "R1 latch after reset", 32'(pin_out), 32'h0);
        @(negedge clk);
        rst_n = 1'b1;
        settle();

        chk(exp_q.size() == 0, "R4 scoreboard drained", 32'(exp_q.size()), 32'd0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule